// File: doc/BRIEF.md
# BCH Correction Write-Back Engine

This engine repairs one ECC sector after the decoder has found it correctable. It reads the error locations and error values that the decoder left in its result registers. It sorts each location into one of three places and XORs the error value into the matching byte. The three places are the sector's bytes in the page data buffer, the three protected bytes at the start of the spare area, and the parity bytes stored for that sector near the end of the spare area. Both storage targets are word-wide register files. Each correction is a read-modify-write of one 32-bit word, with the error value shifted into the right byte lane.

A controller pulses `start` with a set of values: the sector number, the error count, the strength code, the sector-size select, the spare-area size and the number of sectors in the page. The engine captures these values at the start pulse. It then walks the errors one at a time in register order and reports completion with a one-cycle `done`. The strength sets the parity length per sector. The sector size sets both the data/spare boundary and the padding span, which place the parity bytes. A parity location that falls outside the spare area is skipped and reported on a sticky flag.

Top module: `ecc_fix_applier`

## Requirements
- R1: Error value i is byte lane (i mod 4) of value register i/4, with lane 0 in bits [7:0] and lane 3 in bits [31:24].
- R2: Error location i is an 11-bit offset taken from location register i/2. Bits [10:0] hold even i and bits [26:16] hold odd i. All other bits of the register are ignored.
- R3: The sector size S is 512 when `sec_big`=0 and 1024 when it is 1. An offset below S XORs the value into byte (sector*S + offset) of the data buffer, which is word (byte/4), lane (byte mod 4).
- R4: An offset from S to S+2 XORs the value into spare word 0, lane (offset − S).
- R5: The parity length P is 15 for strength code 0, 23 for code 1, and 45 for codes 2 and 3. The padding D is 32 for S=512 and 64 for S=1024. A larger offset maps to spare byte A = spare_size − P*sector_count + P*sector + (offset − (S + D − P)).
- R6: A parity correction is a read-modify-write of spare word A/4 that XORs the value at lane (A mod 4). The other three lanes are written back unchanged.
- R7: If A < 0 or A ≥ spare_size, the error causes no write and sets `range_err`. The flag stays set until the next accepted start clears it.
- R8: An error count above 24 is treated as 24. A count of 0 writes nothing and gives `done` in the first cycle after the start edge.
- R9: For n errors, correction i is applied in the cycle that follows clock edge 3i+2 after the start edge, and no two writes happen in adjacent cycles. `done` is a one-cycle pulse after edge 3n. `busy` is high from the start edge up to and including the `done` cycle.
- R10: While `busy` is high, `start` and changes to the set-up inputs do not affect the corrections already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a correction pass (accepted when idle) |
| sec_idx | input | 4 | Sector number within the page |
| err_cnt | input | 5 | Number of errors reported by the decoder |
| strength | input | 2 | Strength code: 0, 1, or 2/3 |
| sec_big | input | 1 | Sector size select: 0 = 512 bytes, 1 = 1024 bytes |
| spare_size | input | 9 | Spare-area size in bytes |
| sec_cnt | input | 5 | Sectors per page |
| loc_idx | output | 4 | Location register index |
| loc_word | input | 32 | Location register contents |
| val_idx | output | 3 | Value register index |
| val_word | input | 32 | Value register contents |
| buf_addr | output | 12 | Data buffer word address |
| buf_rdata | input | 32 | Data buffer read word (combinational) |
| buf_wdata | output | 32 | Data buffer write word |
| buf_we | output | 1 | Data buffer write enable |
| spr_addr | output | 7 | Spare register file word address |
| spr_rdata | input | 32 | Spare read word (combinational) |
| spr_wdata | output | 32 | Spare write word |
| spr_we | output | 1 | Spare write enable |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Sticky out-of-range parity location |

## Verification
A wrong region decision or a wrong address calculation shows up in the same cycle as the write. The wrong enable, word address or lane appears on the write port three cycles after that error's registers are fetched. The bench compares every cycle against a schedule built from the requirements, so the first bad write is reported in the cycle it occurs. A fault in the sequencer shows up instead as a wrong write spacing or a `done` in the wrong cycle. A wrong unpacking or a lost configuration shows up as a write data or address mismatch in that correction's cycle. Errors in the sticky flag are reported at the end of the pass and during the idle cycles that follow it.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_MAP,
      ST_APPLY,
      ST_DONE
   } fix_state_t;

   typedef enum logic [1:0] {
      RG_DATA,
      RG_PROT,
      RG_PARITY,
      RG_NONE
   } fix_region_t;

   function automatic logic [5:0] parity_bytes(input logic [1:0] code);
      case (code)
         2'd0:    parity_bytes = 6'd15;
         2'd1:    parity_bytes = 6'd23;
         default: parity_bytes = 6'd45;
      endcase
   endfunction

   function automatic logic [6:0] pad_bytes(input logic big);
      pad_bytes = big ? 7'd64 : 7'd32;
   endfunction

endpackage

// File: rtl/efp_unpack.sv
module efp_unpack #(
   parameter int CNT_W = 5,
   parameter int LI_W  = 4,
   parameter int VI_W  = 3
) (
   input  logic [CNT_W-1:0] idx,
   output logic [LI_W-1:0]  loc_idx,
   input  logic [31:0]      loc_word,
   output logic [VI_W-1:0]  val_idx,
   input  logic [31:0]      val_word,
   output logic [10:0]      loc,
   output logic [7:0]       val
);
   logic [7:0] lanes [4];
   logic       unused_bits;

   assign loc_idx = LI_W'(idx >> 1);
   assign val_idx = VI_W'(idx >> 2);

   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign lanes[g] = val_word[8*g +: 8];
   end

   assign val = lanes[idx[1:0]];
   assign loc = idx[0] ? loc_word[26:16] : loc_word[10:0];
   assign unused_bits = ^{loc_word[15:11], loc_word[31:27]};
endmodule

// File: rtl/efp_locmap.sv
module efp_locmap
   import ecc_fix_pkg::*;
#(
   parameter int SIDX_W  = 4,
   parameter int SPARE_W = 9,
   localparam int BYTE_W = SIDX_W + 10,
   localparam int BUF_AW = BYTE_W - 2,
   localparam int SPR_AW = SPARE_W - 2
) (
   input  logic [10:0]        off,
   input  logic [SIDX_W-1:0]  sidx,
   input  logic [1:0]         strength,
   input  logic               big,
   input  logic [SPARE_W-1:0] spare_size,
   input  logic [SIDX_W:0]    scnt,
   output fix_region_t        region,
   output logic [BUF_AW-1:0]  buf_word,
   output logic [SPR_AW-1:0]  spr_word,
   output logic [1:0]         lane
);
   logic [10:0]       ss;
   logic [5:0]        par;
   logic [6:0]        pad;
   logic [BYTE_W-1:0] d_byte;
   logic signed [15:0] p_abs;
   logic signed [15:0] p_lim;

   assign ss     = big ? 11'd1024 : 11'd512;
   assign par    = parity_bytes(strength);
   assign pad    = pad_bytes(big);
   assign d_byte = ({sidx, 10'b0} >> (big ? 0 : 1)) + BYTE_W'(off);
   assign p_abs  = 16'(int'(spare_size) - int'(par) * int'(scnt) + int'(par) * int'(sidx)
                     + int'(off) - (int'(ss) + int'(pad) - int'(par)));
   assign p_lim  = $signed(16'(spare_size));

   always_comb begin
      buf_word = d_byte[BYTE_W-1:2];
      spr_word = '0;
      lane     = d_byte[1:0];
      if (off < ss) begin
         region = RG_DATA;
      end else if (off < ss + 11'd3) begin
         region = RG_PROT;
         lane   = off[1:0];
      end else if (p_abs < 0 || p_abs >= p_lim) begin
         region = RG_NONE;
      end else begin
         region   = RG_PARITY;
         spr_word = p_abs[SPARE_W-1:2];
         lane     = p_abs[1:0];
      end
   end
endmodule

// File: rtl/ecc_fix_applier.sv
module ecc_fix_applier
   import ecc_fix_pkg::*;
#(
   parameter int MAX_SECT = 16,
   parameter int SPARE_W  = 9,
   parameter int MAX_ERR  = 24,
   localparam int SIDX_W   = $clog2(MAX_SECT),
   localparam int CNT_W    = $clog2(MAX_ERR + 1),
   localparam int LOC_REGS = (MAX_ERR + 1) / 2,
   localparam int VAL_REGS = (MAX_ERR + 3) / 4,
   localparam int LI_W     = (LOC_REGS > 1) ? $clog2(LOC_REGS) : 1,
   localparam int VI_W     = (VAL_REGS > 1) ? $clog2(VAL_REGS) : 1,
   localparam int BUF_AW   = SIDX_W + 8,
   localparam int SPR_AW   = SPARE_W - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [SIDX_W-1:0]  sec_idx,
   input  logic [CNT_W-1:0]   err_cnt,
   input  logic [1:0]         strength,
   input  logic               sec_big,
   input  logic [SPARE_W-1:0] spare_size,
   input  logic [SIDX_W:0]    sec_cnt,
   output logic [LI_W-1:0]    loc_idx,
   input  logic [31:0]        loc_word,
   output logic [VI_W-1:0]    val_idx,
   input  logic [31:0]        val_word,
   output logic [BUF_AW-1:0]  buf_addr,
   input  logic [31:0]        buf_rdata,
   output logic [31:0]        buf_wdata,
   output logic               buf_we,
   output logic [SPR_AW-1:0]  spr_addr,
   input  logic [31:0]        spr_rdata,
   output logic [31:0]        spr_wdata,
   output logic               spr_we,
   output logic               busy,
   output logic               done,
   output logic               range_err
);
   if (MAX_ERR < 1 || MAX_ERR > 24) begin : g_chk_err
      $error("MAX_ERR must lie in 1..24");
   end
   if (MAX_SECT < 2 || (MAX_SECT & (MAX_SECT - 1)) != 0) begin : g_chk_sect
      $error("MAX_SECT must be a power of two of at least 2");
   end
   if (SPARE_W < 9 || SPARE_W > 15) begin : g_chk_spare
      $error("SPARE_W must lie in 9..15");
   end

   fix_state_t         state;
   logic [CNT_W-1:0]   idx_q, cnt_q, cnt_clamped;
   logic [SIDX_W-1:0]  sidx_q;
   logic [1:0]         str_q;
   logic               big_q;
   logic [SPARE_W-1:0] ssz_q;
   logic [SIDX_W:0]    scnt_q;
   logic [10:0]        loc_d, loc_q;
   logic [7:0]         val_d, val_q;
   fix_region_t        rg_d, rg_q;
   logic [BUF_AW-1:0]  bw_d;
   logic [SPR_AW-1:0]  sw_d;
   logic [1:0]         ln_d, ln_q;
   logic [31:0]        xmask;
   logic               accept;

   assign accept      = start && (state == ST_IDLE);
   assign cnt_clamped = (err_cnt > CNT_W'(MAX_ERR)) ? CNT_W'(MAX_ERR) : err_cnt;

   efp_unpack #(.CNT_W(CNT_W), .LI_W(LI_W), .VI_W(VI_W)) u_unpack (
      .idx      (idx_q),
      .loc_idx  (loc_idx),
      .loc_word (loc_word),
      .val_idx  (val_idx),
      .val_word (val_word),
      .loc      (loc_d),
      .val      (val_d)
   );

   efp_locmap #(.SIDX_W(SIDX_W), .SPARE_W(SPARE_W)) u_map (
      .off        (loc_q),
      .sidx       (sidx_q),
      .strength   (str_q),
      .big        (big_q),
      .spare_size (ssz_q),
      .scnt       (scnt_q),
      .region     (rg_d),
      .buf_word   (bw_d),
      .spr_word   (sw_d),
      .lane       (ln_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx_q     <= '0;
         cnt_q     <= '0;
         sidx_q    <= '0;
         str_q     <= '0;
         big_q     <= 1'b0;
         ssz_q     <= '0;
         scnt_q    <= '0;
         loc_q     <= '0;
         val_q     <= '0;
         rg_q      <= RG_NONE;
         buf_addr  <= '0;
         spr_addr  <= '0;
         ln_q      <= '0;
         range_err <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               sidx_q    <= sec_idx;
               str_q     <= strength;
               big_q     <= sec_big;
               ssz_q     <= spare_size;
               scnt_q    <= sec_cnt;
               cnt_q     <= cnt_clamped;
               idx_q     <= '0;
               range_err <= 1'b0;
               state     <= (cnt_clamped == '0) ? ST_DONE : ST_FETCH;
            end
            ST_FETCH: begin
               loc_q <= loc_d;
               val_q <= val_d;
               state <= ST_MAP;
            end
            ST_MAP: begin
               rg_q     <= rg_d;
               buf_addr <= bw_d;
               spr_addr <= sw_d;
               ln_q     <= ln_d;
               state    <= ST_APPLY;
            end
            ST_APPLY: begin
               if (rg_q == RG_NONE) range_err <= 1'b1;
               idx_q <= idx_q + 1'b1;
               state <= (CNT_W'(idx_q + 1'b1) == cnt_q) ? ST_DONE : ST_FETCH;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < 4; g++) begin : g_mask
      assign xmask[8*g +: 8] = (ln_q == 2'(g)) ? val_q : 8'h00;
   end

   assign buf_wdata = buf_rdata ^ xmask;
   assign spr_wdata = spr_rdata ^ xmask;
   assign buf_we    = (state == ST_APPLY) && (rg_q == RG_DATA);
   assign spr_we    = (state == ST_APPLY) && (rg_q == RG_PROT || rg_q == RG_PARITY);
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we || spr_we) |=> !(buf_we || spr_we));
   a_r7_range_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (range_err && !accept) |=> range_err);
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx_q <= cnt_q && cnt_q <= CNT_W'(MAX_ERR)));
   a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> ($stable(sidx_q) && $stable(ssz_q) && $stable(str_q)));
endmodule

// File: tb/test_ecc_fix_applier.sv
`timescale 1ns/1ps
module test_ecc_fix_applier;
   localparam int MS  = 4;
   localparam int SW  = 9;
   localparam int ME  = 24;
   localparam int BAW = 10;
   localparam int SAW = 7;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [1:0] sec_idx = '0;
   logic [4:0] err_cnt = '0;
   logic [1:0] strength = '0;
   logic sec_big = 1'b0;
   logic [8:0] spare_size = '0;
   logic [2:0] sec_cnt = '0;
   logic [3:0] loc_idx;
   logic [2:0] val_idx;
   logic [31:0] loc_word, val_word, buf_rdata, buf_wdata, spr_rdata, spr_wdata;
   logic [BAW-1:0] buf_addr;
   logic [SAW-1:0] spr_addr;
   logic buf_we, spr_we, busy, done, range_err;

   logic [31:0] locr [12];
   logic [31:0] valr [6];
   logic [31:0] bmem [1024];
   logic [31:0] smem [128];
   logic [31:0] emem [1024];
   logic [31:0] esmem [128];
   int c_off [24];
   int c_val [24];
   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   ecc_fix_applier #(.MAX_SECT(MS), .SPARE_W(SW), .MAX_ERR(ME)) i_ecc_fix_applier (
      .clk(clk), .rst_n(rst_n), .start(start), .sec_idx(sec_idx), .err_cnt(err_cnt),
      .strength(strength), .sec_big(sec_big), .spare_size(spare_size), .sec_cnt(sec_cnt),
      .loc_idx(loc_idx), .loc_word(loc_word), .val_idx(val_idx), .val_word(val_word),
      .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_wdata(buf_wdata), .buf_we(buf_we),
      .spr_addr(spr_addr), .spr_rdata(spr_rdata), .spr_wdata(spr_wdata), .spr_we(spr_we),
      .busy(busy), .done(done), .range_err(range_err));

   assign loc_word  = locr[loc_idx];
   assign val_word  = valr[val_idx];
   assign buf_rdata = bmem[buf_addr];
   assign spr_rdata = smem[spr_addr];

   always @(posedge clk) begin
      if (buf_we) bmem[buf_addr] <= buf_wdata;
      if (spr_we) smem[spr_addr] <= spr_wdata;
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // kind: 0 data buffer, 1 spare file, 2 skipped (out of range)
   task automatic ref_map(input int sidx, big, str, ssz, scnt, off,
                          output int kind, output int wa, output int lane);
      int s, d, p, b;
      s = big ? 1024 : 512;
      d = big ? 64 : 32;
      p = (str == 0) ? 15 : (str == 1) ? 23 : 45;
      if (off < s) begin
         b = sidx * s + off; kind = 0; wa = b / 4; lane = b % 4;
      end else if (off < s + 3) begin
         kind = 1; wa = 0; lane = off - s;
      end else begin
         b = ssz - p * scnt + p * sidx + (off - (s + d - p));
         if (b < 0 || b >= ssz) begin kind = 2; wa = 0; lane = 0; end
         else begin kind = 1; wa = b / 4; lane = b % 4; end
      end
   endtask

   task automatic run_case(input string tag, input int sidx, cnt, str, big, ssz, scnt,
                           input bit hold);
      int n, L, ix;
      int kind [24];
      int wa [24];
      int ln [24];
      logic [31:0] ew;
      bit any_bad;
      n = (cnt > 24) ? 24 : cnt;
      L = 3 * n + 1;
      any_bad = 0;
      for (int i = 0; i < 12; i++) locr[i] = 32'hF800_F800;
      for (int i = 0; i < 6; i++) valr[i] = 32'h0;
      for (int i = 0; i < n; i++) begin
         ref_map(sidx, big, str, ssz, scnt, c_off[i], kind[i], wa[i], ln[i]);
         if (kind[i] == 2) any_bad = 1;
         locr[i/2] = locr[i/2] | (32'(c_off[i]) << (16 * (i % 2)));
         valr[i/4] = valr[i/4] | (32'(c_val[i] & 8'hFF) << (8 * (i % 4)));
      end
      @(negedge clk);
      sec_idx = 2'(sidx); err_cnt = 5'(cnt); strength = 2'(str); sec_big = big[0];
      spare_size = 9'(ssz); sec_cnt = 3'(scnt); start = 1'b1;
      @(posedge clk);
      for (int k = 1; k <= L; k++) begin
         @(negedge clk);
         check({tag, " R9 busy/done"}, {62'd0, busy, done}, {62'd0, 1'b1, (k == L)});
         ix = (k % 3 == 0) ? (k / 3 - 1) : -1;
         if (ix >= 0 && ix < n && kind[ix] == 0) begin
            ew = emem[wa[ix]] ^ (32'(c_val[ix] & 8'hFF) << (8 * ln[ix]));
            check({tag, " data write"}, {buf_we, spr_we, 20'(buf_addr), buf_wdata},
                  {1'b1, 1'b0, 20'(wa[ix]), ew});
            emem[wa[ix]] = ew;
         end else if (ix >= 0 && ix < n && kind[ix] == 1) begin
            ew = esmem[wa[ix]] ^ (32'(c_val[ix] & 8'hFF) << (8 * ln[ix]));
            check({tag, " spare write"}, {buf_we, spr_we, 20'(spr_addr), spr_wdata},
                  {1'b0, 1'b1, 20'(wa[ix]), ew});
            esmem[wa[ix]] = ew;
         end else begin
            check({tag, " R9 no write"}, {62'd0, buf_we, spr_we}, 64'd0);
         end
         if (hold && k < L) begin
            // R10: keep start high and disturb the set-up inputs mid-pass
            start = 1'b1; sec_idx = ~sec_idx; strength = ~strength; spare_size = ~spare_size;
         end else begin
            start = 1'b0;
         end
      end
      @(negedge clk);
      check({tag, " R9 idle after done"}, {62'd0, busy, done}, 64'd0);
      check({tag, " R7 range flag"}, {63'd0, range_err}, {63'd0, any_bad});
      begin
         int bad = 0;
         for (int a = 0; a < 1024; a++) if (bmem[a] !== emem[a]) bad++;
         for (int a = 0; a < 128; a++) if (smem[a] !== esmem[a]) bad++;
         check({tag, " memory image"}, 64'(bad), 64'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int a = 0; a < 1024; a++) begin
         bmem[a] = 32'(a) * 32'h0101_0101 ^ 32'hA500_0000; emem[a] = bmem[a];
      end
      for (int a = 0; a < 128; a++) begin
         smem[a] = 32'(a) * 32'h0303_0303 ^ 32'h005A_0000; esmem[a] = smem[a];
      end
      for (int i = 0; i < 12; i++) locr[i] = '0;
      for (int i = 0; i < 6; i++) valr[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset state", {60'd0, busy, done, buf_we | spr_we, range_err}, 64'd0);

      // R1 R2 R3: value lanes, location halves with junk bits, data region
      c_off[0] = 0; c_off[1] = 7; c_off[2] = 511;
      c_val[0] = 8'h01; c_val[1] = 8'h80; c_val[2] = 8'h3C;
      run_case("R3", 2, 3, 0, 0, 64, 4, 0);
      // R4: protected spare bytes
      c_off[0] = 512; c_off[1] = 513; c_off[2] = 514; c_off[3] = 3;
      c_val[0] = 8'h11; c_val[1] = 8'h22; c_val[2] = 8'h33; c_val[3] = 8'h44;
      run_case("R4", 0, 4, 1, 0, 64, 4, 0);
      // R5 R6 with R10: t=12 parity bytes while start held and inputs disturbed
      c_off[0] = 521; c_off[1] = 543;
      c_val[0] = 8'hF0; c_val[1] = 8'h0F;
      run_case("R10", 1, 2, 1, 0, 64, 2, 1);
      // R5 R6: t=24, 1024-byte sectors, parity plus a data byte
      c_off[0] = 1043; c_off[1] = 1087; c_off[2] = 1023;
      c_val[0] = 8'h5A; c_val[1] = 8'hC3; c_val[2] = 8'h99;
      run_case("R6", 1, 3, 2, 1, 128, 2, 0);
      // R7: parity location beyond the spare area, then a valid byte
      c_off[0] = 527; c_off[1] = 5;
      c_val[0] = 8'h77; c_val[1] = 8'h66;
      run_case("R7", 2, 2, 0, 0, 32, 1, 0);
      repeat (4) @(negedge clk);
      check("R7 sticky while idle", {63'd0, range_err}, 64'd1);
      // R7: negative spare position
      c_off[0] = 527; c_val[0] = 8'h12;
      run_case("R7", 0, 1, 0, 0, 32, 4, 0);
      // R8: count above 24 clamps to 24 (also clears R7 flag)
      for (int i = 0; i < 24; i++) begin c_off[i] = i * 9; c_val[i] = i + 1; end
      run_case("R8", 1, 30, 0, 0, 64, 4, 0);
      // R8: zero count
      run_case("R8", 3, 0, 0, 0, 64, 4, 0);
      // R5: strength code 3 behaves as code 2
      c_off[0] = 1043; c_val[0] = 8'hAA;
      run_case("R5", 0, 1, 3, 1, 128, 2, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule